// File: doc/BRIEF.md
# Interleaved VRB-to-PRB Bundle Mapper

This block turns a virtual resource block allocation inside a common-search-space bandwidth into the physical resource block order used by interleaved downlink data mapping. It takes the region size in RBs, the start of the bandwidth part, the start of the control region and the bundle length L (2 or 4). From these it cuts the region into bundles whose edges follow the combined start offset modulo L. It permutes all bundles but the final one through a two-row block interleaver.

A start pulse latches the configuration. The block then spends one cycle per bundle building a table of bundle base offsets, with its output quiet. After that it streams one PRB index per cycle, ordered by ascending VRB, and ends with a one-cycle done flag. An illegal configuration is refused with a one-cycle error flag. While a job is running, further start pulses are ignored.

Top module: `vrb_prb_interleaver`

## Requirements
- R1: A start in idle with L other than 2 or 4, a region size of 0 or above 275, or either start offset above 274 gives `cfg_err` high for exactly one cycle, the cycle after the start edge, with `busy` low and no valid beat or done.
- R2: With o = (bwp_start + cset_start) mod L, the bundle count is ceil((N + o) / L), and bundle 0 holds L − o RBs.
- R3: The last bundle holds (N + bwp_start + cset_start) mod L RBs, or L when that is zero, and every middle bundle holds L. When there is only one bundle, it holds all N RBs.
- R4: For a bundle j other than the last, with C = floor(count / 2), VRB bundle j is placed at PRB bundle (j mod 2)·C + floor(j / 2).
- R5: The last bundle is placed at its own index.
- R6: The k-th RB of VRB bundle j is output as (total size of bundles below its PRB bundle) + k. Beats go by ascending j, then ascending k, and there are exactly N of them.
- R7: After an accepted start, `prb_valid` is low through a setup of one cycle per bundle. The first index is visible in the cycle that follows bundle-count + 1 clock edges after the start edge, and the beats then follow on every cycle with no gap.
- R8: `done` is high for one cycle, the cycle right after the last valid beat.
- R9: A start pulse while `busy` is high, whatever the configuration inputs hold, does not change the running stream and raises no `cfg_err`.
- R10: For N = 48, L = 2 and both starts 0, the stream begins 0, 1, 24, 25, 2, 3, 26, 27 and ends 22, 23, 46, 47.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Job request, sampled while idle |
| cfg_rb_count | input | RB_W | Region size N in RBs |
| cfg_bwp_start | input | RB_W | Bandwidth-part start |
| cfg_cset_start | input | RB_W | Control-region start |
| cfg_bundle_len | input | 3 | Bundle length L (2 or 4) |
| prb_valid | output | 1 | PRB index beat valid |
| prb_idx | output | RB_W | PRB index for the current VRB |
| done | output | 1 | One-cycle end-of-job flag |
| cfg_err | output | 1 | One-cycle illegal-configuration flag |
| busy | output | 1 | Job in setup, stream or done cycle |

## Verification
The bench picks offsets whose sum is not a multiple of L, so that bundle 0 is short and the last bundle is either short or full. A design that aligns bundles to zero would then emit a shifted index stream. It runs odd and even bundle counts, a single-bundle case where N is smaller than L, and a two-bundle case. These catch a wrong column count C, an interleaved last bundle, or a single bundle sized L − o instead of N, each of which shows up as a mismatched or missing beat. It also measures the setup latency and whether done follows the last beat at once, fires starts with new and with illegal settings in the middle of a stream to expose a restart, and runs the largest legal region to find overflow in the base-offset sums.

// File: rtl/vrbmap_pkg.sv
package vrbmap_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETUP  = 2'd1,
      ST_STREAM = 2'd2,
      ST_FIN    = 2'd3
   } vm_state_e;

   localparam int SZ_W = 3;   // bundle sizes never exceed 4
endpackage

// File: rtl/vrbmap_geom.sv
module vrbmap_geom
   import vrbmap_pkg::*;
#(
   parameter int RB_W      = 9,
   parameter int NB_W      = 8,
   parameter int MAX_RB    = 275,
   parameter int MAX_START = 274
) (
   input  logic [RB_W-1:0] n_rb,
   input  logic [RB_W-1:0] bwp_s,
   input  logic [RB_W-1:0] cs_s,
   input  logic [2:0]      len,
   output logic            ok,
   output logic [NB_W-1:0] nb,
   output logic [SZ_W-1:0] first_sz,
   output logic [SZ_W-1:0] last_sz
);
   logic            is4;
   logic [1:0]      mask;
   logic [RB_W:0]   ofs_sum;
   logic [1:0]      ofs;
   logic [RB_W+1:0] span;
   logic [RB_W+1:0] tail;
   logic [1:0]      rem;
   logic [RB_W+1:0] nb_full;

   always_comb begin
      is4     = (len == 3'd4);
      mask    = is4 ? 2'd3 : 2'd1;
      ofs_sum = {1'b0, bwp_s} + {1'b0, cs_s};
      ofs     = ofs_sum[1:0] & mask;
      span    = {2'b00, n_rb} + {{RB_W{1'b0}}, ofs} + {{RB_W{1'b0}}, mask};
      nb_full = is4 ? (span >> 2) : (span >> 1);
      nb      = NB_W'(nb_full);
      tail    = {2'b00, n_rb} + {1'b0, ofs_sum};
      rem     = tail[1:0] & mask;
      last_sz = (rem == 2'd0) ? len : {1'b0, rem};
      first_sz = (nb == NB_W'(1)) ? n_rb[SZ_W-1:0] : (len - {1'b0, ofs});
      ok = ((len == 3'd2) || is4) && (n_rb != '0) &&
           (n_rb <= RB_W'(MAX_RB)) && (bwp_s <= RB_W'(MAX_START)) &&
           (cs_s <= RB_W'(MAX_START));
   end
endmodule

// File: rtl/vrbmap_ilv.sv
module vrbmap_ilv #(
   parameter int NB_W = 8
) (
   input  logic [NB_W-1:0] j,
   input  logic [NB_W-1:0] nb,
   output logic [NB_W-1:0] f
);
   logic [NB_W-1:0] cols;

   always_comb begin
      cols = nb >> 1;
      if (j == nb - NB_W'(1))
         f = j;
      else
         f = (j[0] ? cols : '0) + (j >> 1);
   end
endmodule

// File: rtl/vrbmap_tbl.sv
module vrbmap_tbl #(
   parameter int DEPTH = 139,
   parameter int AW    = 8,
   parameter int DW    = 9
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] ent [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
      always_ff @(posedge clk) begin
         if (we && (waddr == AW'(gi)))
            ent[gi] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < DEPTH; i++)
         if (raddr == AW'(i))
            rdata = ent[i];
   end
endmodule

// File: rtl/vrb_prb_interleaver.sv
module vrb_prb_interleaver
   import vrbmap_pkg::*;
#(
   parameter int MAX_RB    = 275,
   parameter int MAX_START = 274,
   parameter int RB_W      = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [RB_W-1:0] cfg_rb_count,
   input  logic [RB_W-1:0] cfg_bwp_start,
   input  logic [RB_W-1:0] cfg_cset_start,
   input  logic [2:0]      cfg_bundle_len,
   output logic            prb_valid,
   output logic [RB_W-1:0] prb_idx,
   output logic            done,
   output logic            cfg_err,
   output logic            busy
);
   localparam int MAX_NB = MAX_RB / 2 + 2;
   localparam int NB_W   = $clog2(MAX_NB + 1);

   if (MAX_RB < 1) begin : g_bad_rb
      $error("MAX_RB must be at least 1");
   end
   if (RB_W < $clog2(MAX_RB + 1) || RB_W < $clog2(MAX_START + 1)) begin : g_bad_w
      $error("RB_W too narrow for MAX_RB or MAX_START");
   end

   vm_state_e       state;
   logic [RB_W-1:0] n_q, bwp_q, cs_q;
   logic [2:0]      l_q;
   logic [NB_W-1:0] idx_q;
   logic [SZ_W-1:0] k_q;
   logic [RB_W-1:0] acc_q;
   logic            err_q;

   logic [RB_W-1:0] g_n, g_b, g_c;
   logic [2:0]      g_l;
   logic            g_ok;
   logic [NB_W-1:0] nb;
   logic [SZ_W-1:0] first_sz, last_sz, cur_sz;
   logic [NB_W-1:0] ilv_f;
   logic [RB_W-1:0] base;
   logic            idle;

   assign idle = (state == ST_IDLE);

   always_comb begin
      g_n = idle ? cfg_rb_count   : n_q;
      g_b = idle ? cfg_bwp_start  : bwp_q;
      g_c = idle ? cfg_cset_start : cs_q;
      g_l = idle ? cfg_bundle_len : l_q;
   end

   vrbmap_geom #(.RB_W(RB_W), .NB_W(NB_W), .MAX_RB(MAX_RB), .MAX_START(MAX_START)) u_geom (
      .n_rb(g_n), .bwp_s(g_b), .cs_s(g_c), .len(g_l),
      .ok(g_ok), .nb(nb), .first_sz(first_sz), .last_sz(last_sz)
   );

   always_comb begin
      if (idx_q == '0)
         cur_sz = first_sz;
      else if (idx_q == nb - NB_W'(1))
         cur_sz = last_sz;
      else
         cur_sz = l_q;
   end

   vrbmap_ilv #(.NB_W(NB_W)) u_ilv (.j(idx_q), .nb(nb), .f(ilv_f));

   vrbmap_tbl #(.DEPTH(MAX_NB), .AW(NB_W), .DW(RB_W)) u_tbl (
      .clk(clk), .we(state == ST_SETUP), .waddr(idx_q), .wdata(acc_q),
      .raddr(ilv_f), .rdata(base)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         n_q   <= '0;
         bwp_q <= '0;
         cs_q  <= '0;
         l_q   <= 3'd2;
         idx_q <= '0;
         k_q   <= '0;
         acc_q <= '0;
         err_q <= 1'b0;
      end else begin
         err_q <= idle && start && !g_ok;
         unique case (state)
            ST_IDLE: if (start && g_ok) begin
               n_q   <= cfg_rb_count;
               bwp_q <= cfg_bwp_start;
               cs_q  <= cfg_cset_start;
               l_q   <= cfg_bundle_len;
               idx_q <= '0;
               k_q   <= '0;
               acc_q <= '0;
               state <= ST_SETUP;
            end
            ST_SETUP: begin
               acc_q <= acc_q + RB_W'(cur_sz);
               if (idx_q == nb - NB_W'(1)) begin
                  idx_q <= '0;
                  k_q   <= '0;
                  state <= ST_STREAM;
               end else begin
                  idx_q <= idx_q + NB_W'(1);
               end
            end
            ST_STREAM: begin
               if (k_q == cur_sz - SZ_W'(1)) begin
                  k_q <= '0;
                  if (idx_q == nb - NB_W'(1))
                     state <= ST_FIN;
                  else
                     idx_q <= idx_q + NB_W'(1);
               end else begin
                  k_q <= k_q + SZ_W'(1);
               end
            end
            ST_FIN: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign prb_valid = (state == ST_STREAM);
   assign prb_idx   = base + RB_W'(k_q);
   assign done      = (state == ST_FIN);
   assign cfg_err   = err_q;
   assign busy      = !idle;

   // R1: a refused job leaves the block idle and silent
   assert_err_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (!busy && !prb_valid && !done));
   // R4: interleaver output stays inside the bundle range
   assert_perm_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      prb_valid |-> (ilv_f < nb));
   // R5: last bundle is not permuted
   assert_last_self_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (prb_valid && idx_q == nb - NB_W'(1)) |-> (ilv_f == idx_q));
   // R6: every emitted index lies inside the region
   assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      prb_valid |-> (prb_idx < n_q));
   // R7: no beat in the cycle after a job is accepted
   assert_setup_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !prb_valid);
   // R8: done directly follows a valid beat
   assert_done_after_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(prb_valid));
   // R9: latched configuration is held for the whole job
   assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(n_q) && $stable(l_q) && $stable(bwp_q) && $stable(cs_q)));
endmodule

// File: tb/tb_vrb_prb_interleaver.sv
module tb_vrb_prb_interleaver;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [8:0] cfg_rb_count = '0, cfg_bwp_start = '0, cfg_cset_start = '0;
   logic [2:0] cfg_bundle_len = 3'd2;
   logic       prb_valid, done, cfg_err, busy;
   logic [8:0] prb_idx;

   int n_checks = 0, n_fail = 0;
   int expq[$];
   int beats = 0;
   bit last_valid = 0;
   bit err_allowed = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   vrb_prb_interleaver dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_rb_count(cfg_rb_count), .cfg_bwp_start(cfg_bwp_start),
      .cfg_cset_start(cfg_cset_start), .cfg_bundle_len(cfg_bundle_len),
      .prb_valid(prb_valid), .prb_idx(prb_idx), .done(done),
      .cfg_err(cfg_err), .busy(busy)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (prb_valid) begin
            if (expq.size() == 0) begin
               check(0, "R6 unexpected beat", prb_idx, -1);
            end else begin
               int e;
               e = expq.pop_front();
               check(prb_idx == e, "R6 index", prb_idx, e);
            end
            beats++;
         end
         if (done) begin
            check(last_valid, "R8 done after last beat", last_valid, 1);
            check(expq.size() == 0, "R6 beats left at done", expq.size(), 0);
         end
         if (cfg_err && !err_allowed)
            check(0, "R9 spurious cfg_err", 1, 0);
         last_valid = prb_valid;
      end
   end

   // expected stream from R2..R6
   function automatic int push_expected(int n, int b, int c, int l);
      int sz[300];
      int pref[300];
      int o, nb, f;
      o  = (b + c) % l;
      nb = (n + o + l - 1) / l;
      for (int j = 0; j < nb; j++) begin
         if (nb == 1) sz[j] = n;                                         // R3
         else if (j == 0) sz[j] = l - o;                                 // R2
         else if (j == nb - 1) sz[j] = ((n + b + c) % l == 0) ? l : (n + b + c) % l; // R3
         else sz[j] = l;
      end
      pref[0] = 0;
      for (int j = 1; j < nb; j++) pref[j] = pref[j-1] + sz[j-1];
      for (int j = 0; j < nb; j++) begin
         f = (j == nb - 1) ? j : (j % 2) * (nb / 2) + j / 2;             // R4, R5
         for (int k = 0; k < sz[j]; k++) expq.push_back(pref[f] + k);
      end
      return nb;
   endfunction

   task automatic run_case(input int n, input int b, input int c, input int l, input bit poke);
      int nb, lat, guard;
      nb = push_expected(n, b, c, l);
      beats = 0;
      @(negedge clk);
      cfg_rb_count = 9'(n); cfg_bwp_start = 9'(b); cfg_cset_start = 9'(c); cfg_bundle_len = 3'(l);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      guard = 0;
      while (!prb_valid && guard < 1000) begin
         @(negedge clk); lat++; guard++;
      end
      check(lat == nb + 1, "R7 setup latency", lat, nb + 1);
      if (poke) begin
         repeat (2) @(negedge clk);
         // R9: restart attempts with a legal and an illegal setting
         cfg_rb_count = 9'd10; cfg_bundle_len = 3'd4; start = 1'b1;
         @(negedge clk);
         cfg_bundle_len = 3'd3;
         @(negedge clk);
         start = 1'b0;
      end
      guard = 0;
      while (!done && guard < 2000) begin
         @(negedge clk); guard++;
      end
      check(beats == n, "R6/R7 beat count", beats, n);
      check(expq.size() == 0, "R6 queue drained", expq.size(), 0);
      @(negedge clk);
      check(!busy && !done, "R8 done one cycle", done, 0);
   endtask

   task automatic run_bad(input int n, input int b, input int c, input int l);
      @(negedge clk);
      err_allowed = 1;
      cfg_rb_count = 9'(n); cfg_bwp_start = 9'(b); cfg_cset_start = 9'(c); cfg_bundle_len = 3'(l);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(cfg_err == 1'b1, "R1 cfg_err raised", cfg_err, 1);
      check(busy == 1'b0, "R1 stays idle", busy, 0);
      @(negedge clk);
      check(cfg_err == 1'b0, "R1 cfg_err one cycle", cfg_err, 0);
      repeat (4) begin
         @(negedge clk);
         check(!prb_valid && !done, "R1 no output", prb_valid, 0);
      end
      err_allowed = 0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!prb_valid && !done && !cfg_err && !busy, "reset state", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: 48 RBs, L=2, zero starts: check stream head and tail directly
      begin
         int nb, head[8], tail[4];
         int h_exp[8] = '{0, 1, 24, 25, 2, 3, 26, 27};
         int t_exp[4] = '{22, 23, 46, 47};
         nb = push_expected(48, 0, 0, 2);
         for (int i = 0; i < 8; i++) check(expq[i] == h_exp[i], "R10 head model", expq[i], h_exp[i]);
         for (int i = 0; i < 4; i++) check(expq[44+i] == t_exp[i], "R10 tail model", expq[44+i], t_exp[i]);
         check(nb == 24, "R2 bundle count", nb, 24);
         expq.delete();
      end
      run_case(48, 0, 0, 2, 0);   // R10 on hardware
      run_case(48, 1, 2, 2, 0);   // R2 short first bundle, 25 bundles
      run_case(37, 1, 2, 4, 0);   // R2/R3 first=1, last full
      run_case(38, 2, 3, 4, 0);   // R3 short last bundle
      run_case(50, 3, 1, 4, 0);   // R4 aligned L=4
      run_case(1, 3, 0, 4, 0);    // R3 single bundle of N
      run_case(2, 0, 1, 2, 0);    // R5 two bundles
      run_case(60, 5, 0, 2, 1);   // R9 mid-stream starts ignored
      run_case(275, 274, 274, 2, 0); // largest region
      run_case(275, 1, 0, 4, 0);

      run_bad(48, 0, 0, 3);       // R1 bad L
      run_bad(0, 0, 0, 2);        // R1 empty region
      run_bad(276, 0, 0, 2);      // R1 oversize region
      run_bad(10, 275, 0, 4);     // R1 bwp start out of range
      run_bad(10, 0, 300, 2);     // R1 control start out of range

      run_case(9, 3, 3, 4, 0);    // back to normal after errors
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule